// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block sequences instruction fetch for a small microcontroller core. It holds an 11-bit program counter that addresses a 2K-word program memory. The memory is split into two pages of 1024 words. Each cycle the counter either advances, holds, or takes a new value from a control event: a jump, a call, one of three return forms, or an accepted interrupt.

Jump and call instructions carry only a 10-bit in-page offset. The page bit comes from a status register that sits outside the block and arrives on its own input. Calls and interrupts save a return address on an eight-entry circular hardware stack. Returns take the address back from the top of that stack. Two fixed vectors share the address space: reset starts fetch at word 0x000, and an accepted interrupt redirects fetch to word 0x003.

Instruction decode drives the control inputs with one-hot strobes. Program memory reads the fetch address directly.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the fetch address is 0x000 and both stack flags are low.
- R2: With advance high and no other strobe, the fetch address rises by one each clock. It wraps from 0x7FF to 0x000. With no strobe at all, the fetch address holds.
- R3: A jump loads the fetch address with the page bit (address bit 10) above the 10-bit target offset (bits 9:0). Page 0 covers 0x000–0x3FF and page 1 covers 0x400–0x7FF.
- R4: A call loads the fetch address the same way as a jump. It also pushes the address that follows the call (current address + 1, modulo 2K).
- R5: Return, return-with-literal and return-from-interrupt each pop the stack and load the popped address. Entries come back in last-in, first-out order.
- R6: An interrupt accept pushes the current fetch address and loads 0x003. It overrides every other strobe in the same cycle.
- R7: When several strobes are high together, the priority is interrupt, then call, then jump, then any return, then advance.
- R8: The stack holds eight entries and its pointer wraps. A ninth push without an intervening pop overwrites the oldest entry and sets the overflow flag. The flag stays set until reset. Eight pushes alone do not set it.
- R9: A pop from an empty stack returns storage slot 0 and leaves the pointer and the entry count unchanged. It sets the underflow flag, which stays set until reset. Slot 0 reads 0x000 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ack_i | input | 1 | Interrupt accepted this cycle |
| adv_i | input | 1 | Advance to the next sequential word |
| jmp_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Plain return strobe |
| retl_i | input | 1 | Return-with-literal strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| target_i | input | 10 | In-page target offset for jump and call |
| page_i | input | 1 | Page-select bit from the status register |
| fetch_addr_o | output | 11 | Program memory fetch address |
| ovf_o | output | 1 | Sticky stack overflow flag |
| udf_o | output | 1 | Sticky stack underflow flag |

## Verification
The assertions treat the control strobes as sampled on the rising edge. They also rely on the internal decode never requesting a push and a pop in the same cycle. The jump and call properties only compare the new address with the previous cycle's page bit and target when no strobe of higher priority was also high. The bench changes inputs only on falling edges and holds every strobe low during reset. It raises several strobes together only in the vectors written to test priority.

// File: rtl/pc_sequencer_pkg.sv
package pc_sequencer_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_ADV,
    OP_JMP,
    OP_CALL,
    OP_POP,
    OP_IRQ
  } seq_op_e;
endpackage

// File: rtl/pc_op_decode.sv
module pc_op_decode
  import pc_sequencer_pkg::*;
(
  input  logic    irq_ack_i,
  input  logic    adv_i,
  input  logic    jmp_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    retl_i,
  input  logic    reti_i,
  output seq_op_e op_o
);
  // fixed priority: interrupt > call > jump > return > advance
  always_comb begin
    if (irq_ack_i)                      op_o = OP_IRQ;
    else if (call_i)                    op_o = OP_CALL;
    else if (jmp_i)                     op_o = OP_JMP;
    else if (ret_i || retl_i || reti_i) op_o = OP_POP;
    else if (adv_i)                     op_o = OP_ADV;
    else                                op_o = OP_HOLD;
  end
endmodule

// File: rtl/pc_next.sv
module pc_next
  import pc_sequencer_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned OFS_W  = 10,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 'h003
) (
  input  seq_op_e               op_i,
  input  logic [ADDR_W-1:0]     pc_i,
  input  logic [OFS_W-1:0]      target_i,
  input  logic [ADDR_W-OFS_W-1:0] page_i,
  input  logic [ADDR_W-1:0]     top_i,
  output logic [ADDR_W-1:0]     pc_nxt_o,
  output logic                  push_o,
  output logic                  pop_o,
  output logic [ADDR_W-1:0]     push_data_o
);
  logic [ADDR_W-1:0] pc_inc;
  assign pc_inc = pc_i + ADDR_W'(1);

  always_comb begin
    pc_nxt_o    = pc_i;
    push_o      = 1'b0;
    pop_o       = 1'b0;
    push_data_o = pc_inc;
    unique case (op_i)
      OP_ADV:  pc_nxt_o = pc_inc;
      OP_JMP:  pc_nxt_o = {page_i, target_i};
      OP_CALL: begin
        pc_nxt_o = {page_i, target_i};
        push_o   = 1'b1;
      end
      OP_POP: begin
        pc_nxt_o = top_i;
        pop_o    = 1'b1;
      end
      OP_IRQ: begin
        // resume at the interrupted word
        pc_nxt_o    = IRQ_VEC;
        push_o      = 1'b1;
        push_data_o = pc_i;
      end
      default: pc_nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_data_i,
  output logic [ADDR_W-1:0] top_o,
  output logic              ovf_o,
  output logic              udf_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     sp_q, sp_inc, sp_dec;
  logic [CW-1:0]     cnt_q;
  logic              empty, full;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == FULL);
  assign sp_inc = (sp_q == LAST) ? '0 : sp_q + PW'(1);
  assign sp_dec = (sp_q == '0) ? LAST : sp_q - PW'(1);
  assign top_o  = empty ? mem_q[0] : mem_q[sp_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else if (push_i) begin
      sp_q <= sp_inc;
      if (full) ovf_o <= 1'b1;
      else      cnt_q <= cnt_q + CW'(1);
    end else if (pop_i) begin
      if (empty) udf_o <= 1'b1;
      else begin
        sp_q  <= sp_dec;
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[sp_q] <= push_data_i;
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R8
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) |=> ovf_o);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R9
  udf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty) |=> (udf_o && $stable(sp_q) && $stable(cnt_q)));
  // R9
  udf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |=> udf_o);
  // R7
  push_pop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_sequencer_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned OFS_W  = 10,
  parameter int unsigned DEPTH  = 8,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 'h003
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    irq_ack_i,
  input  logic                    adv_i,
  input  logic                    jmp_i,
  input  logic                    call_i,
  input  logic                    ret_i,
  input  logic                    retl_i,
  input  logic                    reti_i,
  input  logic [OFS_W-1:0]        target_i,
  input  logic [ADDR_W-OFS_W-1:0] page_i,
  output logic [ADDR_W-1:0]       fetch_addr_o,
  output logic                    ovf_o,
  output logic                    udf_o
);
  seq_op_e           op;
  logic [ADDR_W-1:0] pc_q, pc_nxt, top, push_data;
  logic              push, pop;

  pc_op_decode u_decode (
    .irq_ack_i(irq_ack_i), .adv_i(adv_i), .jmp_i(jmp_i), .call_i(call_i),
    .ret_i(ret_i), .retl_i(retl_i), .reti_i(reti_i), .op_o(op)
  );

  pc_next #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IRQ_VEC(IRQ_VEC)) u_next (
    .op_i(op), .pc_i(pc_q), .target_i(target_i), .page_i(page_i),
    .top_i(top), .pc_nxt_o(pc_nxt), .push_o(push), .pop_o(pop),
    .push_data_o(push_data)
  );

  pc_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .push_data_i(push_data), .top_o(top), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nxt;
  end

  assign fetch_addr_o = pc_q;

  logic any_ret;
  assign any_ret = ret_i || retl_i || reti_i;

  // R2
  adv_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !irq_ack_i && !call_i && !jmp_i && !any_ret)
      |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1));
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !irq_ack_i && !call_i && !jmp_i && !any_ret)
      |=> $stable(fetch_addr_o));
  // R3
  jmp_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_i && !irq_ack_i && !call_i)
      |=> fetch_addr_o == {$past(page_i), $past(target_i)});
  // R4
  call_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !irq_ack_i)
      |=> fetch_addr_o == {$past(page_i), $past(target_i)});
  // R6
  irq_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> fetch_addr_o == IRQ_VEC);
endmodule

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_ack = 0, adv = 0, jmp = 0, call = 0, ret = 0, retl = 0, reti = 0;
  logic [9:0] target = '0;
  logic       page = 1'b0;
  logic [10:0] fetch;
  logic       ovf, udf;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .irq_ack_i(irq_ack), .adv_i(adv),
    .jmp_i(jmp), .call_i(call), .ret_i(ret), .retl_i(retl), .reti_i(reti),
    .target_i(target), .page_i(page), .fetch_addr_o(fetch),
    .ovf_o(ovf), .udf_o(udf)
  );

  // ctrl bits: 6 irq, 5 adv, 4 jmp, 3 call, 2 ret, 1 retl, 0 reti
  typedef struct packed {
    logic [6:0]  ctrl;
    logic        pg;
    logic [9:0]  tgt;
    logic [10:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{7'h20, 1'b0, 10'h000, 11'h001},  // R2 advance
    '{7'h20, 1'b0, 10'h000, 11'h002},  // R2
    '{7'h10, 1'b1, 10'h155, 11'h555},  // R3 jump to page 1
    '{7'h08, 1'b0, 10'h020, 11'h020},  // R4 call, push 0x556
    '{7'h20, 1'b0, 10'h000, 11'h021},  // R2
    '{7'h08, 1'b1, 10'h3FF, 11'h7FF},  // R4 call, push 0x022
    '{7'h20, 1'b0, 10'h000, 11'h000},  // R2 wrap
    '{7'h04, 1'b0, 10'h000, 11'h022},  // R5 ret
    '{7'h02, 1'b0, 10'h000, 11'h556},  // R5 retl
    '{7'h60, 1'b0, 10'h000, 11'h003},  // R6 irq over advance, push 0x556
    '{7'h01, 1'b0, 10'h000, 11'h556},  // R5 reti
    '{7'h00, 1'b1, 10'h2AA, 11'h556},  // R2 hold
    '{7'h48, 1'b0, 10'h010, 11'h003},  // R7 irq over call, push 0x556
    '{7'h18, 1'b0, 10'h040, 11'h040},  // R7 call over jump, push 0x004
    '{7'h14, 1'b1, 10'h100, 11'h500},  // R7 jump over ret
    '{7'h04, 1'b0, 10'h000, 11'h004}   // R5 ret
  };

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] c, input logic pg, input logic [9:0] t);
    @(negedge clk);
    {irq_ack, adv, jmp, call, ret, retl, reti} = c;
    page   = pg;
    target = t;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    {irq_ack, adv, jmp, call, ret, retl, reti} = '0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 fetch in reset", fetch, 11'h000);
    chk("R1 ovf in reset", {10'd0, ovf}, 11'h0);
    chk("R1 udf in reset", {10'd0, udf}, 11'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 fetch after reset", fetch, 11'h000);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].ctrl, VECS[i].pg, VECS[i].tgt);
      chk($sformatf("table vec %0d", i), fetch, VECS[i].exp);
    end
    step(7'h00, 1'b0, 10'h000);
    chk("R8 no ovf in normal use", {10'd0, ovf}, 11'h0);
    chk("R9 no udf in normal use", {10'd0, udf}, 11'h0);

    // R9 underflow: empty pop returns slot 0, pointer unchanged
    do_reset();
    step(7'h04, 1'b0, 10'h000);
    chk("R9 empty pop addr", fetch, 11'h000);
    chk("R9 udf set", {10'd0, udf}, 11'h1);
    step(7'h20, 1'b0, 10'h000);
    step(7'h08, 1'b0, 10'h100);  // push 0x002
    chk("R4 call target", fetch, 11'h100);
    step(7'h04, 1'b0, 10'h000);
    chk("R9 pointer unchanged after empty pop", fetch, 11'h002);
    chk("R9 udf sticky", {10'd0, udf}, 11'h1);

    // R8 overflow: nine calls, oldest lost
    do_reset();
    for (int i = 1; i <= 8; i++) begin
      step(7'h08, 1'b0, 10'(i * 16));
    end
    chk("R8 eight pushes no ovf", {10'd0, ovf}, 11'h0);
    step(7'h08, 1'b0, 10'h090);  // push 0x081 over oldest
    chk("R8 ninth push ovf", {10'd0, ovf}, 11'h1);
    for (int i = 9; i >= 2; i--) begin
      step(7'h04, 1'b0, 10'h000);
      chk($sformatf("R8 pop order %0d", i), fetch, 11'((i - 1) * 16 + 1));
    end
    chk("R9 no udf before empty", {10'd0, udf}, 11'h0);
    step(7'h01, 1'b0, 10'h000);
    chk("R9 empty pop returns slot 0", fetch, 11'h081);
    chk("R9 udf after overflow drain", {10'd0, udf}, 11'h1);
    chk("R8 ovf sticky", {10'd0, ovf}, 11'h1);

    // R1 reset clears flags
    do_reset();
    #1;
    chk("R1 flags cleared", {9'd0, ovf, udf}, 11'h0);
    chk("R1 fetch cleared", fetch, 11'h000);

    finish_run();
  end
endmodule